// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Match Qualifier

This block decides, every cycle, whether any of a set of hardware breakpoint or watchpoint comparators should raise a debug event. Each comparator unit is described by a 32-bit control word and a value word, both supplied by the surrounding register file. A breakpoint unit becomes a candidate when it is enabled and its value equals the program counter. A watchpoint unit becomes a candidate when it is enabled and the memory system reports a raw address hit for it. Each candidate is then qualified by the security state, by a privilege mask for the current level, and optionally by a link to a context-identifier comparator held in the breakpoint bank.

The per-unit results and their OR are registered, so every output reflects the inputs of the previous cycle. The block also produces the watchpoint compare address, adjusted for byte-invariant big-endian accesses.

Top module: `dbg_match_qual`

## Requirements
- R1: No unit reports a match unless bit 15 of `dbg_ctrl` is 1 and `evt_allow` is 1.
- R2: A breakpoint unit matches only when its enable bit (control bit 0) is 1 and its value word equals `pc`.
- R3: A watchpoint unit matches only when its enable bit (control bit 0) is 1 and its `wp_hit` bit is 1.
- R4: Security control (control bits 15:14) value 0 allows either state, values 1 and 3 allow only non-secure (`secure`=0), and value 2 allows only secure.
- R5: At level 2 or 3 the higher-level bit (control bit 13) must be 1; at level 1 mask bit 1 must be 1; at level 0 mask bit 2 must be 1.
- R6: A watchpoint whose `wp_unpriv` bit is 1 is qualified as level 0, whatever `cur_lvl` is.
- R7: When the link bit (control bit 20) is 1, the linked index (control bits 19:16) must satisfy brps minus ctx <= index <= brps, with brps = `id_word`[27:24] and ctx = `id_word`[23:20], and must name an existing breakpoint unit; otherwise no match.
- R8: A link succeeds only when the linked breakpoint unit is enabled, its type (control bits 23:20) is 3, `cur_lvl` is 0 or 1, and `ctx_id` equals the low bits of its value word.
- R9: `wp_addr_adj` is `wp_addr` XOR 3 for size code 0 (1 byte) and XOR 2 for size code 1 (2 bytes) when `bi_be` is 1; in all other cases it equals `wp_addr`.
- R10: `bp_vec`/`wp_vec` bits and their ORs `bp_match`/`wp_match` appear one cycle after the inputs, last one cycle per qualifying cycle, and are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| secure | input | 1 | 1 when executing in the secure state |
| pc | input | AW | Program counter |
| dbg_ctrl | input | 32 | Debug control word; bit 15 enables monitor debug |
| evt_allow | input | 1 | Debug events otherwise permitted |
| id_word | input | 32 | Debug identification word with comparator counts |
| ctx_id | input | CTXW | Current context identifier |
| bp_ctrl | input | NBP*32 | Breakpoint control words, unit i at bits 32*i+31:32*i |
| bp_val | input | NBP*AW | Breakpoint value words |
| wp_ctrl | input | NWP*32 | Watchpoint control words |
| wp_hit | input | NWP | Raw address hit per watchpoint |
| wp_unpriv | input | NWP | Hit came from an unprivileged access |
| wp_addr | input | AW | Watchpoint access address |
| wp_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| bi_be | input | 1 | Byte-invariant big-endian mode |
| bp_vec | output | NBP | Registered per-breakpoint match |
| wp_vec | output | NWP | Registered per-watchpoint match |
| bp_match | output | 1 | Any breakpoint matched |
| wp_match | output | 1 | Any watchpoint matched |
| wp_addr_adj | output | AW | Registered endian-adjusted watch address |

## Verification
A table sweeps one breakpoint through every privilege level against complementary mask and higher-level settings, and through all four security codes in both states, so a swapped mask bit or a mis-decoded security code shows as a single wrong row. Directed cases then separate the candidate conditions (pc mismatch, disabled unit, absent raw hit), the unprivileged override against a mask that admits only level 1 or only level 0, and the link path: an index inside and outside the identification range, a disabled or wrong-type target, a context mismatch and a level above 1. Address adjustment is tried for each size with the endian mode on and off.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;

    localparam int CTRL_W    = 32;
    localparam int MDE_BIT   = 15;
    localparam int EN_BIT    = 0;
    localparam int PAC_LO    = 1;
    localparam int HMC_BIT   = 13;
    localparam int SSC_LO    = 14;
    localparam int LBN_LO    = 16;
    localparam int BT_LO     = 20;
    localparam int ID_BRP_LO = 24;
    localparam int ID_CTX_LO = 20;
    localparam logic [3:0] CTX_MATCH_TYPE = 4'd3;

    typedef logic [1:0] lvl_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SEC_ANY   = 2'd0,
        SEC_NS_A  = 2'd1,
        SEC_ONLY  = 2'd2,
        SEC_NS_B  = 2'd3
    } sec_ctl_e;

    typedef struct packed {
        logic       en;
        logic [1:0] pac;
        logic       hmc;
        sec_ctl_e   ssc;
        logic [3:0] lbn;
        logic       link;
        logic [3:0] btype;
    } unit_cfg_t;

    function automatic unit_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
        unit_cfg_t c;
        c.en    = w[EN_BIT];
        c.pac   = w[PAC_LO +: 2];
        c.hmc   = w[HMC_BIT];
        c.ssc   = sec_ctl_e'(w[SSC_LO +: 2]);
        c.lbn   = w[LBN_LO +: 4];
        c.link  = w[BT_LO];
        c.btype = w[BT_LO +: 4];
        return c;
    endfunction

endpackage

// File: rtl/dbgq_qual.sv
module dbgq_qual
    import dbgq_pkg::*;
(
    input  unit_cfg_t cfg,
    input  lvl_t      lvl,
    input  logic      secure,
    output logic      pass
);

    logic sec_ok;
    logic lvl_ok;

    always_comb begin
        unique case (cfg.ssc)
            SEC_ANY:  sec_ok = 1'b1;
            SEC_ONLY: sec_ok = secure;
            default:  sec_ok = !secure;
        endcase
    end

    always_comb begin
        unique case (lvl)
            2'd0:    lvl_ok = cfg.pac[1];
            2'd1:    lvl_ok = cfg.pac[0];
            default: lvl_ok = cfg.hmc;
        endcase
    end

    assign pass = sec_ok && lvl_ok;

    logic unused_cfg;
    assign unused_cfg = ^{cfg.en, cfg.lbn, cfg.link, cfg.btype};

    always_comb begin
        if (cfg.ssc == SEC_ONLY && secure === 1'b0) begin
            p_sec_r4: assert (pass !== 1'b1);
        end
    end

endmodule

// File: rtl/dbgq_link.sv
module dbgq_link
    import dbgq_pkg::*;
#(
    parameter int NBP  = 4,
    parameter int AW   = 32,
    parameter int CTXW = 32
) (
    input  logic [NBP*CTRL_W-1:0] bp_ctrl,
    input  logic [NBP*AW-1:0]     bp_val,
    input  logic [3:0]            lbn,
    input  logic [31:0]           id_word,
    input  lvl_t                  lvl,
    input  logic [CTXW-1:0]       ctx_id,
    output logic                  ok
);

    logic [3:0]  brps;
    logic [3:0]  nctx;
    logic        range_ok;
    logic        exists;
    unit_cfg_t   tgt;
    logic [AW-1:0] tgt_val;

    assign brps = id_word[ID_BRP_LO +: 4];
    assign nctx = id_word[ID_CTX_LO +: 4];

    // index must sit in [brps - ctx, brps]; written without subtraction
    assign range_ok = (lbn <= brps) &&
                      (({1'b0, lbn} + {1'b0, nctx}) >= {1'b0, brps});
    assign exists   = int'(lbn) < NBP;

    always_comb begin
        tgt     = '0;
        tgt_val = '0;
        for (int i = 0; i < NBP; i++) begin
            if (int'(lbn) == i) begin
                tgt     = decode_ctrl(bp_ctrl[i*CTRL_W +: CTRL_W]);
                tgt_val = bp_val[i*AW +: AW];
            end
        end
    end

    assign ok = range_ok && exists && tgt.en &&
                (tgt.btype == CTX_MATCH_TYPE) &&
                (lvl <= 2'd1) &&
                (ctx_id == tgt_val[CTXW-1:0]);

    logic unused_link;
    assign unused_link = ^{id_word, tgt, tgt_val, bp_ctrl};

    always_comb begin
        if (lvl === 2'd2 || lvl === 2'd3) begin
            p_lvl_r8: assert (ok !== 1'b1);
        end
    end

endmodule

// File: rtl/dbgq_waddr.sv
module dbgq_waddr
    import dbgq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  acc_size_e     size,
    input  logic          bi_be,
    output logic [AW-1:0] adj
);

    logic [1:0] flip;

    always_comb begin
        flip = 2'b00;
        if (bi_be) begin
            unique case (size)
                SZ_BYTE: flip = 2'b11;
                SZ_HALF: flip = 2'b10;
                default: flip = 2'b00;
            endcase
        end
    end

    assign adj = {addr[AW-1:2], addr[1:0] ^ flip};

    always_comb begin
        if (bi_be === 1'b0) begin
            p_passthru_r9: assert (adj === addr || $isunknown(addr));
        end
    end

endmodule

// File: rtl/dbg_match_qual.sv
module dbg_match_qual
    import dbgq_pkg::*;
#(
    parameter int NBP  = 4,
    parameter int NWP  = 4,
    parameter int AW   = 32,
    parameter int CTXW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cur_lvl,
    input  logic                  secure,
    input  logic [AW-1:0]         pc,
    input  logic [31:0]           dbg_ctrl,
    input  logic                  evt_allow,
    input  logic [31:0]           id_word,
    input  logic [CTXW-1:0]       ctx_id,
    input  logic [NBP*32-1:0]     bp_ctrl,
    input  logic [NBP*AW-1:0]     bp_val,
    input  logic [NWP*32-1:0]     wp_ctrl,
    input  logic [NWP-1:0]        wp_hit,
    input  logic [NWP-1:0]        wp_unpriv,
    input  logic [AW-1:0]         wp_addr,
    input  logic [1:0]            wp_size,
    input  logic                  bi_be,
    output logic [NBP-1:0]        bp_vec,
    output logic [NWP-1:0]        wp_vec,
    output logic                  bp_match,
    output logic                  wp_match,
    output logic [AW-1:0]         wp_addr_adj
);

    typedef struct packed {
        logic [NBP-1:0] bp_vec;
        logic [NWP-1:0] wp_vec;
        logic           bp_any;
        logic           wp_any;
        logic [AW-1:0]  waddr;
    } state_t;

    state_t st_d, st_q;

    logic           gate;
    logic [NBP-1:0] bp_hit;
    logic [NWP-1:0] wp_qual;
    logic [AW-1:0]  adj_w;

    assign gate = dbg_ctrl[MDE_BIT] && evt_allow;

    generate
        for (genvar i = 0; i < NBP; i++) begin : g_bp
            unit_cfg_t cfg;
            logic      pass;
            logic      link_ok;

            assign cfg = decode_ctrl(bp_ctrl[i*CTRL_W +: CTRL_W]);

            dbgq_qual u_qual (
                .cfg    (cfg),
                .lvl    (cur_lvl),
                .secure (secure),
                .pass   (pass)
            );

            dbgq_link #(.NBP(NBP), .AW(AW), .CTXW(CTXW)) u_link (
                .bp_ctrl (bp_ctrl),
                .bp_val  (bp_val),
                .lbn     (cfg.lbn),
                .id_word (id_word),
                .lvl     (cur_lvl),
                .ctx_id  (ctx_id),
                .ok      (link_ok)
            );

            assign bp_hit[i] = gate && cfg.en &&
                               (bp_val[i*AW +: AW] == pc) &&
                               pass && (!cfg.link || link_ok);

            p_bp_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !bp_ctrl[i*CTRL_W + EN_BIT] |=> !bp_vec[i]);
        end

        for (genvar j = 0; j < NWP; j++) begin : g_wp
            unit_cfg_t cfg;
            lvl_t      eff_lvl;
            logic      pass;
            logic      link_ok;

            assign cfg     = decode_ctrl(wp_ctrl[j*CTRL_W +: CTRL_W]);
            assign eff_lvl = wp_unpriv[j] ? 2'd0 : cur_lvl;

            dbgq_qual u_qual (
                .cfg    (cfg),
                .lvl    (eff_lvl),
                .secure (secure),
                .pass   (pass)
            );

            dbgq_link #(.NBP(NBP), .AW(AW), .CTXW(CTXW)) u_link (
                .bp_ctrl (bp_ctrl),
                .bp_val  (bp_val),
                .lbn     (cfg.lbn),
                .id_word (id_word),
                .lvl     (cur_lvl),
                .ctx_id  (ctx_id),
                .ok      (link_ok)
            );

            assign wp_qual[j] = gate && cfg.en && wp_hit[j] &&
                                pass && (!cfg.link || link_ok);

            p_wp_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !wp_hit[j] |=> !wp_vec[j]);
        end
    endgenerate

    dbgq_waddr #(.AW(AW)) u_waddr (
        .addr  (wp_addr),
        .size  (acc_size_e'(wp_size)),
        .bi_be (bi_be),
        .adj   (adj_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.bp_vec = bp_hit;
        st_d.wp_vec = wp_qual;
        st_d.bp_any = |bp_hit;
        st_d.wp_any = |wp_qual;
        st_d.waddr  = adj_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bp_vec      = st_q.bp_vec;
    assign wp_vec      = st_q.wp_vec;
    assign bp_match    = st_q.bp_any;
    assign wp_match    = st_q.wp_any;
    assign wp_addr_adj = st_q.waddr;

    logic unused_top;
    assign unused_top = ^{dbg_ctrl, wp_ctrl, bp_ctrl};

    p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_ctrl[MDE_BIT] && evt_allow) |=> (bp_vec == '0 && wp_vec == '0));

    p_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_match == (bp_vec != '0)) && (wp_match == (wp_vec != '0)));

endmodule

// File: tb/sim_dbg_match_qual.sv
module sim_dbg_match_qual;

    localparam int NBP = 4;
    localparam int NWP = 4;
    localparam int AW  = 32;
    localparam int CW  = 32;
    localparam logic [AW-1:0] PC0 = 32'h0000_0400;
    localparam logic [CW-1:0] CTX = 32'h0000_ABCD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cur_lvl = 2'd1;
    logic secure = 1'b0;
    logic [AW-1:0] pc = PC0;
    logic [31:0] dbg_ctrl = 32'h0000_8000;
    logic evt_allow = 1'b1;
    logic [31:0] id_word = 32'h0310_0000;
    logic [CW-1:0] ctx_id = CTX;
    logic [NBP*32-1:0] bp_ctrl = '0;
    logic [NBP*AW-1:0] bp_val = '0;
    logic [NWP*32-1:0] wp_ctrl = '0;
    logic [NWP-1:0] wp_hit = '0;
    logic [NWP-1:0] wp_unpriv = '0;
    logic [AW-1:0] wp_addr = '0;
    logic [1:0] wp_size = 2'd0;
    logic bi_be = 1'b0;
    logic [NBP-1:0] bp_vec;
    logic [NWP-1:0] wp_vec;
    logic bp_match, wp_match;
    logic [AW-1:0] wp_addr_adj;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbg_match_qual #(.NBP(NBP), .NWP(NWP), .AW(AW), .CTXW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .secure(secure), .pc(pc),
        .dbg_ctrl(dbg_ctrl), .evt_allow(evt_allow), .id_word(id_word),
        .ctx_id(ctx_id), .bp_ctrl(bp_ctrl), .bp_val(bp_val), .wp_ctrl(wp_ctrl),
        .wp_hit(wp_hit), .wp_unpriv(wp_unpriv), .wp_addr(wp_addr),
        .wp_size(wp_size), .bi_be(bi_be), .bp_vec(bp_vec), .wp_vec(wp_vec),
        .bp_match(bp_match), .wp_match(wp_match), .wp_addr_adj(wp_addr_adj)
    );

    // {lvl[1:0], secure, sec_ctl[1:0], mask[1:0], hmc, expected}
    localparam int NT = 13;
    localparam logic [8:0] TBL [NT] = '{
        9'b000001001, 9'b000000110, 9'b010000101, 9'b010001010,
        9'b100001100, 9'b100000011, 9'b111000011, 9'b011011100,
        9'b010011101, 9'b011111100, 9'b010111101, 9'b011101101,
        9'b010101100
    };

    function automatic logic [31:0] mk(input logic en, input logic [1:0] pac,
                                       input logic hmc, input logic [1:0] ssc,
                                       input logic [3:0] lbn, input logic [3:0] bt);
        return {8'h00, bt, lbn, ssc, hmc, 10'd0, pac, en};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_units();
        bp_ctrl = '0; bp_val = '0; wp_ctrl = '0; wp_hit = '0; wp_unpriv = '0;
        cur_lvl = 2'd1; secure = 1'b0; ctx_id = CTX; id_word = 32'h0310_0000;
        dbg_ctrl = 32'h0000_8000; evt_allow = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        bp_ctrl[31:0] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd0);
        bp_val[31:0]  = PC0;
        repeat (3) tick();
        chk("R10 reset bp_vec", {60'd0, bp_vec}, 64'd0);
        chk("R10 reset match", {62'd0, bp_match, wp_match}, 64'd0);
        rst_n = 1'b1;
        clear_units();
        tick();

        // R4 R5 privilege and security table on breakpoint unit 0
        for (int k = 0; k < NT; k++) begin
            clear_units();
            cur_lvl = TBL[k][8:7];
            secure  = TBL[k][6];
            bp_ctrl[31:0] = mk(1, TBL[k][3:2], TBL[k][1], TBL[k][5:4], 4'd0, 4'd0);
            bp_val[31:0]  = PC0;
            tick();
            chk($sformatf("R4 R5 row %0d", k), {63'd0, bp_match}, {63'd0, TBL[k][0]});
        end

        // R1 global gate
        clear_units();
        bp_ctrl[31:0] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd0);
        bp_val[31:0] = PC0;
        dbg_ctrl = 32'h0000_7FFF;
        tick();
        chk("R1 ctrl bit clear", {63'd0, bp_match}, 64'd0);
        dbg_ctrl = 32'h0000_8000; evt_allow = 1'b0;
        tick();
        chk("R1 events blocked", {63'd0, bp_match}, 64'd0);
        evt_allow = 1'b1;
        tick();
        chk("R1 gate open", {63'd0, bp_match}, 64'd1);

        // R2 candidate conditions
        pc = PC0 + 4;
        tick();
        chk("R2 pc mismatch", {63'd0, bp_match}, 64'd0);
        pc = PC0;
        bp_ctrl[0] = 1'b0;
        tick();
        chk("R2 disabled unit", {63'd0, bp_match}, 64'd0);

        // R10 two units together, then pulse ends
        clear_units();
        bp_ctrl[31:0]  = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd0);
        bp_ctrl[95:64] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd0);
        bp_val[31:0] = PC0; bp_val[95:64] = PC0;
        tick();
        chk("R10 two units vec", {60'd0, bp_vec}, 64'h5);
        chk("R10 or", {63'd0, bp_match}, 64'd1);
        pc = PC0 + 8;
        tick();
        chk("R10 pulse ends", {60'd0, bp_vec, 3'd0, bp_match}, 64'd0);
        pc = PC0;

        // R3 watchpoint raw hit
        clear_units();
        wp_ctrl[95:64] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd0);
        tick();
        chk("R3 no raw hit", {63'd0, wp_match}, 64'd0);
        wp_hit = 4'b0100;
        tick();
        chk("R3 raw hit", {60'd0, wp_vec}, 64'h4);
        wp_ctrl[64] = 1'b0;
        tick();
        chk("R3 disabled", {63'd0, wp_match}, 64'd0);

        // R6 unprivileged override
        clear_units();
        wp_ctrl[31:0] = mk(1, 2'b01, 0, 2'd0, 4'd0, 4'd0);
        wp_hit = 4'b0001; wp_unpriv = 4'b0001; cur_lvl = 2'd1;
        tick();
        chk("R6 unpriv level1 mask", {63'd0, wp_match}, 64'd0);
        wp_unpriv = 4'b0000;
        tick();
        chk("R6 priv level1 mask", {63'd0, wp_match}, 64'd1);
        wp_ctrl[31:0] = mk(1, 2'b10, 0, 2'd0, 4'd0, 4'd0);
        cur_lvl = 2'd2; wp_unpriv = 4'b0001;
        tick();
        chk("R6 unpriv at level2", {63'd0, wp_match}, 64'd1);

        // R7 R8 context link
        clear_units();
        bp_ctrl[31:0]   = mk(1, 2'b11, 1, 2'd0, 4'd3, 4'd1);
        bp_val[31:0]    = PC0;
        bp_ctrl[127:96] = mk(1, 2'b00, 0, 2'd0, 4'd0, 4'd3);
        bp_val[127:96]  = CTX;
        bp_ctrl[63:32]  = mk(1, 2'b00, 0, 2'd0, 4'd0, 4'd3);
        bp_val[63:32]   = CTX;
        tick();
        chk("R8 link ok", {60'd0, bp_vec}, 64'h1);
        bp_ctrl[19:16] = 4'd1;
        tick();
        chk("R7 index below range", {63'd0, bp_match}, 64'd0);
        bp_ctrl[19:16] = 4'd2;
        bp_ctrl[95:64] = mk(0, 2'b00, 0, 2'd0, 4'd0, 4'd3);
        bp_val[95:64]  = CTX;
        tick();
        chk("R8 target disabled", {63'd0, bp_match}, 64'd0);
        bp_ctrl[95:64] = mk(1, 2'b00, 0, 2'd0, 4'd0, 4'd5);
        tick();
        chk("R8 target type 5", {63'd0, bp_match}, 64'd0);
        bp_ctrl[19:16] = 4'd3;
        ctx_id = 32'h0000_1234;
        tick();
        chk("R8 context mismatch", {63'd0, bp_match}, 64'd0);
        ctx_id = CTX; cur_lvl = 2'd2;
        tick();
        chk("R8 level above 1", {63'd0, bp_match}, 64'd0);
        cur_lvl = 2'd1; id_word = 32'h0400_0000;
        tick();
        chk("R7 range excludes 3", {63'd0, bp_match}, 64'd0);
        id_word = 32'h0310_0000; wp_ctrl[31:0] = mk(1, 2'b11, 1, 2'd0, 4'd3, 4'd1);
        wp_hit = 4'b0001;
        tick();
        chk("R7 watch link in range", {63'd0, wp_match}, 64'd1);

        // R9 address adjust
        clear_units();
        wp_addr = 32'h0000_1000; bi_be = 1'b1; wp_size = 2'd0;
        tick();
        chk("R9 byte", {32'd0, wp_addr_adj}, 64'h1003);
        wp_size = 2'd1;
        tick();
        chk("R9 half", {32'd0, wp_addr_adj}, 64'h1002);
        wp_size = 2'd2;
        tick();
        chk("R9 word", {32'd0, wp_addr_adj}, 64'h1000);
        bi_be = 1'b0; wp_size = 2'd0; wp_addr = 32'h0000_1001;
        tick();
        chk("R9 little endian", {32'd0, wp_addr_adj}, 64'h1001);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule